// File: doc/BRIEF.md
# Three-Phase Threshold Energy Pulse Accumulator

This block turns a stream of signed per-sample reactive power words into coarse energy counts, one count for each phase. Each phase keeps a wide signed residue. On every sample strobe, nominally one every 125 µs (an 8 kHz strobe), the phase's power word is added to the residue. When the residue reaches a programmable 48-bit threshold, one unit is added to that phase's signed energy register and the threshold is removed from the residue. When the residue falls to minus the threshold, one unit is subtracted and the threshold is added back. Negative reactive power therefore drives the count down.

The power words come already formed by an upstream multiplier. A 2-bit combination mode can force the second phase's contribution to zero. Software reads an energy register with a per-phase read strobe. When clear-on-read is enabled, the strobe returns the present value and the register starts again from zero. A pulse that lands in the same cycle is kept. Counting past the largest positive or most negative value sets a sticky per-phase overflow flag, and the register holds at the limit (or wraps, in the non-saturating variant). With full-scale quadrature inputs, the per-sample word is about 33,516,139. A threshold set to that value yields one count per sample.

Top module: `reactive_energy_accum`

## Requirements
- R1: After reset, all three energy outputs are zero and `ovf` is 3'b000.
- R2: On a sample strobe, a phase whose residue plus power reaches at least `thr` gains exactly one count, visible on the first clock edge after the strobe cycle, and its residue is reduced by `thr`.
- R3: On a sample strobe, a phase whose residue plus power is at or below minus `thr` loses exactly one count, and its residue is increased by `thr`.
- R4: With the power word equal to `thr`, a phase gains one count on every sample strobe.
- R5: In cycles without a sample strobe and without a clearing read, the energy outputs do not change, whatever the power inputs carry.
- R6: With `comb_mode` equal to 2'b01, the second phase (`pwr_b`) is treated as zero. Values 2'b00, 2'b10 and 2'b11 pass `pwr_b` through.
- R7: An increment at the largest positive value (0x7FFFFFFF at the default width) leaves the register at that value and sets the phase's bit of `ovf`. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R8: A decrement at the most negative value (0x80000000 at the default width) leaves the register at that value and sets the phase's bit of `ovf`.
- R9: When `rd_clr_en` is 1, `rd_stb[i]` shows the old value in that cycle. After the edge the register holds zero, or plus or minus one if a pulse arrived in that same cycle.
- R10: When `rd_clr_en` is 0, `rd_stb` has no effect on any energy register.
- R11: An `ovf` bit, once set, stays set until reset, including across clearing reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | One-cycle strobe per power sample |
| pwr_a | input | PWR_W | Signed power word, phase A |
| pwr_b | input | PWR_W | Signed power word, phase B |
| pwr_c | input | PWR_W | Signed power word, phase C |
| thr | input | THR_W | Unsigned pulse threshold |
| comb_mode | input | 2 | Phase combination mode (2'b01 drops phase B) |
| rd_clr_en | input | 1 | Enables clear-on-read |
| rd_stb | input | 3 | Per-phase read strobe (bit 0 A, bit 1 B, bit 2 C) |
| energy_a | output | NRG_W | Signed energy count, phase A |
| energy_b | output | NRG_W | Signed energy count, phase B |
| energy_c | output | NRG_W | Signed energy count, phase C |
| ovf | output | 3 | Sticky overflow flags per phase |

## Verification
The checker takes two things as given: the threshold is nonzero whenever a sample arrives, and no power word exceeds the threshold in magnitude. Under those conditions each sample moves a count by at most one, and a residue stays strictly inside plus or minus the threshold. The bench draws every power word from the closed range minus to plus the threshold, and keeps each threshold nonzero. It changes the threshold only right after a reset, so no residue left over from a larger threshold can break the bound. The saturation cases run with a reduced energy width, so that both limits are reached in a few hundred samples.

// File: rtl/rea_pkg.sv
package rea_pkg;

   localparam int NPH = 3;
   localparam int PH_B = 1;
   localparam logic [1:0] MODE_DROP_B = 2'b01;

   typedef enum logic [1:0] {
      PULSE_NONE = 2'b00,
      PULSE_UP   = 2'b01,
      PULSE_DN   = 2'b10
   } pulse_e;

endpackage

// File: rtl/rea_phase_gate.sv
module rea_phase_gate
   import rea_pkg::*;
#(
   parameter int PWR_W = 32
) (
   input  logic [NPH-1:0][PWR_W-1:0] pwr_in,
   input  logic [1:0]                mode,
   output logic [NPH-1:0][PWR_W-1:0] pwr_out
);

   for (genvar g = 0; g < NPH; g++) begin : g_ph
      if (g == PH_B) begin : g_gated
         assign pwr_out[g] = (mode == MODE_DROP_B) ? '0 : pwr_in[g];
      end else begin : g_pass
         assign pwr_out[g] = pwr_in[g];
      end
   end

endmodule

// File: rtl/rea_residue.sv
module rea_residue
   import rea_pkg::*;
#(
   parameter int PWR_W = 32,
   parameter int THR_W = 48
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sample_vld,
   input  logic signed [PWR_W-1:0] pwr,
   input  logic [THR_W-1:0]        thr,
   output pulse_e                  pulse
);

   localparam int RES_W = THR_W + 2;

   logic signed [RES_W-1:0] res_q;
   logic signed [RES_W-1:0] res_d;
   logic signed [RES_W-1:0] sum;
   logic signed [RES_W-1:0] thr_s;
   pulse_e                  pulse_c;

   always_comb begin
      thr_s   = $signed({2'b00, thr});
      sum     = res_q + $signed({{(RES_W-PWR_W){pwr[PWR_W-1]}}, pwr});
      res_d   = sum;
      pulse_c = PULSE_NONE;
      if (sum >= thr_s) begin
         pulse_c = PULSE_UP;
         res_d   = sum - thr_s;
      end else if (sum <= -thr_s) begin
         pulse_c = PULSE_DN;
         res_d   = sum + thr_s;
      end
   end

   assign pulse = sample_vld ? pulse_c : PULSE_NONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (sample_vld) begin
         res_q <= res_d;
      end
   end

endmodule

// File: rtl/rea_energy_reg.sv
module rea_energy_reg
   import rea_pkg::*;
#(
   parameter int NRG_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pulse_e           pulse,
   input  logic             clr,
   output logic [NRG_W-1:0] nrg,
   output logic             ovf
);

   localparam logic [NRG_W-1:0] TOP_V = {1'b0, {(NRG_W-1){1'b1}}};
   localparam logic [NRG_W-1:0] BOT_V = {1'b1, {(NRG_W-1){1'b0}}};

   logic [NRG_W-1:0] nrg_q;
   logic [NRG_W-1:0] nrg_d;
   logic [NRG_W-1:0] base;
   logic [NRG_W-1:0] past_top;
   logic [NRG_W-1:0] past_bot;
   logic             ovf_q;
   logic             ovf_d;

   if (SATURATE) begin : g_sat
      assign past_top = TOP_V;
      assign past_bot = BOT_V;
   end else begin : g_wrap
      assign past_top = BOT_V;
      assign past_bot = TOP_V;
   end

   always_comb begin
      base  = clr ? '0 : nrg_q;
      nrg_d = base;
      ovf_d = ovf_q;
      unique case (pulse)
         PULSE_UP: begin
            if (base == TOP_V) begin
               nrg_d = past_top;
               ovf_d = 1'b1;
            end else begin
               nrg_d = base + 1'b1;
            end
         end
         PULSE_DN: begin
            if (base == BOT_V) begin
               nrg_d = past_bot;
               ovf_d = 1'b1;
            end else begin
               nrg_d = base - 1'b1;
            end
         end
         default: nrg_d = base;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nrg_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         nrg_q <= nrg_d;
         ovf_q <= ovf_d;
      end
   end

   assign nrg = nrg_q;
   assign ovf = ovf_q;

endmodule

// File: rtl/reactive_energy_accum.sv
module reactive_energy_accum
   import rea_pkg::*;
#(
   parameter int PWR_W    = 32,
   parameter int THR_W    = 48,
   parameter int NRG_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_vld,
   input  logic [PWR_W-1:0] pwr_a,
   input  logic [PWR_W-1:0] pwr_b,
   input  logic [PWR_W-1:0] pwr_c,
   input  logic [THR_W-1:0] thr,
   input  logic [1:0]       comb_mode,
   input  logic             rd_clr_en,
   input  logic [2:0]       rd_stb,
   output logic [NRG_W-1:0] energy_a,
   output logic [NRG_W-1:0] energy_b,
   output logic [NRG_W-1:0] energy_c,
   output logic [2:0]       ovf
);

   initial begin : p_param_chk
      assert (THR_W >= PWR_W)
         else $error("threshold narrower than power word");
      assert (NRG_W >= 2)
         else $error("energy register too narrow");
      assert (PWR_W >= 2)
         else $error("power word too narrow");
   end

   logic [NPH-1:0][PWR_W-1:0] pwr_raw;
   logic [NPH-1:0][PWR_W-1:0] pwr_sel;
   logic [NPH-1:0][NRG_W-1:0] nrg_all;
   logic [NPH-1:0]            clr;
   pulse_e                    pulse [NPH];

   assign pwr_raw = {pwr_c, pwr_b, pwr_a};
   assign clr     = rd_stb & {NPH{rd_clr_en}};

   rea_phase_gate #(.PWR_W(PWR_W)) gate_i (
      .pwr_in  (pwr_raw),
      .mode    (comb_mode),
      .pwr_out (pwr_sel)
   );

   for (genvar p = 0; p < NPH; p++) begin : g_phase
      rea_residue #(.PWR_W(PWR_W), .THR_W(THR_W)) res_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .sample_vld (sample_vld),
         .pwr        ($signed(pwr_sel[p])),
         .thr        (thr),
         .pulse      (pulse[p])
      );

      rea_energy_reg #(.NRG_W(NRG_W), .SATURATE(SATURATE)) nrg_i (
         .clk   (clk),
         .rst_n (rst_n),
         .pulse (pulse[p]),
         .clr   (clr[p]),
         .nrg   (nrg_all[p]),
         .ovf   (ovf[p])
      );
   end

   assign energy_a = nrg_all[0];
   assign energy_b = nrg_all[1];
   assign energy_c = nrg_all[2];

endmodule

// File: rtl/rea_checker.sv
module rea_checker
   import rea_pkg::*;
#(
   parameter int PWR_W = 32,
   parameter int THR_W = 48,
   parameter int NRG_W = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      sample_vld,
   input logic [NPH-1:0][PWR_W-1:0] pwr,
   input logic [THR_W-1:0]          thr,
   input logic [1:0]                comb_mode,
   input logic                      rd_clr_en,
   input logic [2:0]                rd_stb,
   input logic [NPH-1:0][NRG_W-1:0] nrg,
   input logic [2:0]                ovf
);

   localparam logic [NRG_W-1:0] TOP_V = {1'b0, {(NRG_W-1){1'b1}}};
   localparam logic [NRG_W-1:0] BOT_V = {1'b1, {(NRG_W-1){1'b0}}};
   localparam logic [NRG_W-1:0] ONE_V = {{(NRG_W-1){1'b0}}, 1'b1};

   logic [NPH-1:0] clr;
   assign clr = rd_stb & {NPH{rd_clr_en}};

   AST_THR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld |-> thr != '0); // R2

   for (genvar p = 0; p < NPH; p++) begin : g_chk
      logic signed [THR_W+1:0] pw_ext;
      logic signed [THR_W+1:0] th_ext;
      assign pw_ext = $signed({{(THR_W+2-PWR_W){pwr[p][PWR_W-1]}}, pwr[p]});
      assign th_ext = $signed({2'b00, thr});

      AST_PWR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         sample_vld |-> (pw_ext <= th_ext && pw_ext >= -th_ext)); // R3

      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!sample_vld && !clr[p]) |=> $stable(nrg[p])); // R5

      AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (sample_vld && !clr[p]) |=> (nrg[p] == $past(nrg[p])
            || nrg[p] == $past(nrg[p]) + ONE_V
            || nrg[p] == $past(nrg[p]) - ONE_V)); // R2

      AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         clr[p] |=> (nrg[p] == '0 || nrg[p] == ONE_V || nrg[p] == '1)); // R9

      AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         ovf[p] |=> ovf[p]); // R11

      AST_OVF_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ovf[p]) |-> (nrg[p] == TOP_V || nrg[p] == BOT_V)); // R7
   end

   AST_MODE_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld && comb_mode == MODE_DROP_B && !clr[PH_B])
         |=> $stable(nrg[PH_B])); // R6

endmodule

bind reactive_energy_accum rea_checker #(
   .PWR_W(PWR_W),
   .THR_W(THR_W),
   .NRG_W(NRG_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_vld (sample_vld),
   .pwr        (pwr_raw),
   .thr        (thr),
   .comb_mode  (comb_mode),
   .rd_clr_en  (rd_clr_en),
   .rd_stb     (rd_stb),
   .nrg        (nrg_all),
   .ovf        (ovf)
);

// File: tb/reactive_energy_accum_tb_top.sv
`timescale 1ns/1ps
module reactive_energy_accum_tb_top;

   localparam int PWR_W = 32;
   localparam int THR_W = 48;
   localparam int NRG_W = 10;
   localparam longint EMAX = (64'sd1 <<< (NRG_W-1)) - 1;
   localparam longint EMIN = -(64'sd1 <<< (NRG_W-1));

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sample_vld = 1'b0;
   logic [PWR_W-1:0] pwr_a = '0, pwr_b = '0, pwr_c = '0;
   logic [THR_W-1:0] thr = 48'd100;
   logic [1:0]       comb_mode = 2'b00;
   logic             rd_clr_en = 1'b0;
   logic [2:0]       rd_stb = 3'b000;
   logic [NRG_W-1:0] energy_a, energy_b, energy_c;
   logic [2:0]       ovf;

   int     n_cmp = 0;
   int     n_bad = 0;
   string  cur_req = "R1";
   bit     done = 1'b0;

   longint m_res [3];
   longint m_nrg [3];
   bit     m_ovf [3];

   always #2.5 clk = ~clk;

   reactive_energy_accum #(
      .PWR_W(PWR_W), .THR_W(THR_W), .NRG_W(NRG_W), .SATURATE(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
      .pwr_a(pwr_a), .pwr_b(pwr_b), .pwr_c(pwr_c),
      .thr(thr), .comb_mode(comb_mode),
      .rd_clr_en(rd_clr_en), .rd_stb(rd_stb),
      .energy_a(energy_a), .energy_b(energy_b), .energy_c(energy_c),
      .ovf(ovf)
   );

   task automatic chk(string req, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic longint dut_nrg(int p);
      case (p)
         0:       return longint'($signed(energy_a));
         1:       return longint'($signed(energy_b));
         default: return longint'($signed(energy_c));
      endcase
   endfunction

   function automatic longint pwr_of(int p);
      case (p)
         0:       return longint'($signed(pwr_a));
         1:       return longint'($signed(pwr_b));
         default: return longint'($signed(pwr_c));
      endcase
   endfunction

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      for (int p = 0; p < 3; p++) begin
         if (!rst_n) begin
            m_res[p] = 0; m_nrg[p] = 0; m_ovf[p] = 1'b0;
         end else begin
            longint base, s, t;
            int     step;
            step = 0;
            t    = longint'(thr);
            base = (rd_clr_en && rd_stb[p]) ? 0 : m_nrg[p];
            if (sample_vld) begin
               s = m_res[p] + ((p == 1 && comb_mode == 2'b01) ? 0 : pwr_of(p));
               if (s >= t) begin step = 1; s = s - t; end
               else if (s <= -t) begin step = -1; s = s + t; end
               m_res[p] = s;
            end
            if (step == 1) begin
               if (base == EMAX) m_ovf[p] = 1'b1; else base = base + 1;
            end else if (step == -1) begin
               if (base == EMIN) m_ovf[p] = 1'b1; else base = base - 1;
            end
            m_nrg[p] = base;
         end
      end
   end

   // compare against the reference on every falling edge
   always @(negedge clk) begin
      if (!done) begin
         for (int p = 0; p < 3; p++) begin
            chk(cur_req, dut_nrg(p), m_nrg[p]);
            chk(cur_req, longint'(ovf[p]), longint'(m_ovf[p]));
         end
      end
   end

   task automatic tick(bit vld, logic [2:0] rd);
      @(negedge clk);
      sample_vld = vld;
      rd_stb     = rd;
   endtask

   task automatic do_reset(logic [THR_W-1:0] t);
      @(negedge clk);
      rst_n = 1'b0; sample_vld = 1'b0; rd_stb = '0; thr = t;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      finish_run();
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      chk("R1", dut_nrg(0), 0); chk("R1", dut_nrg(1), 0);
      chk("R1", dut_nrg(2), 0); chk("R1", longint'(ovf), 0);

      // r2_ r3_ r4_: steady positive, negative and equal-to-threshold powers
      cur_req = "R2";
      pwr_a = 32'sd30; pwr_b = -32'sd30; pwr_c = 32'sd100;
      for (int i = 0; i < 10; i++) tick(1'b1, 3'b000);
      tick(1'b0, 3'b000);
      chk("R2", dut_nrg(0), 3);
      chk("R3", dut_nrg(1), -3);
      chk("R4", dut_nrg(2), 10);

      // R5: power inputs move, no strobe
      cur_req = "R5";
      pwr_a = 32'sd100; pwr_b = -32'sd100; pwr_c = -32'sd77;
      for (int i = 0; i < 8; i++) tick(1'b0, 3'b000);
      chk("R5", dut_nrg(0), 3); chk("R5", dut_nrg(1), -3); chk("R5", dut_nrg(2), 10);

      // R6: mode 01 drops phase B, mode 11 and 10 pass it
      cur_req = "R6";
      pwr_a = 32'sd0; pwr_c = 32'sd0; pwr_b = 32'sd100;
      comb_mode = 2'b01;
      for (int i = 0; i < 6; i++) tick(1'b1, 3'b000);
      tick(1'b0, 3'b000);
      chk("R6", dut_nrg(1), -3);
      comb_mode = 2'b11;
      for (int i = 0; i < 5; i++) tick(1'b1, 3'b000);
      tick(1'b0, 3'b000);
      chk("R6", dut_nrg(1), 2);
      comb_mode = 2'b10;
      for (int i = 0; i < 2; i++) tick(1'b1, 3'b000);
      tick(1'b0, 3'b000);
      chk("R6", dut_nrg(1), 4);
      comb_mode = 2'b00;

      // R10: strobes without clear-on-read
      cur_req = "R10";
      rd_clr_en = 1'b0;
      tick(1'b0, 3'b111);
      tick(1'b0, 3'b000);
      chk("R10", dut_nrg(0), 3); chk("R10", dut_nrg(1), 4); chk("R10", dut_nrg(2), 10);

      // R9: clearing read of B alone, then a read of C coinciding with a pulse
      cur_req = "R9";
      rd_clr_en = 1'b1;
      tick(1'b0, 3'b010);
      chk("R9", dut_nrg(1), 4);
      tick(1'b0, 3'b000);
      chk("R9", dut_nrg(1), 0); chk("R9", dut_nrg(0), 3);
      pwr_c = 32'sd100; pwr_b = 32'sd0;
      tick(1'b1, 3'b100);
      tick(1'b0, 3'b000);
      chk("R9", dut_nrg(2), 1);
      rd_clr_en = 1'b0;

      // R7 R8: saturation at both limits with a unit threshold
      cur_req = "R7";
      do_reset(48'd1);
      pwr_a = 32'sd1; pwr_b = 32'sd0; pwr_c = -32'sd1;
      for (int i = 0; i < 530; i++) tick(1'b1, 3'b000);
      tick(1'b0, 3'b000);
      chk("R7", dut_nrg(0), EMAX);
      chk("R7", longint'(ovf[0]), 1);
      chk("R8", dut_nrg(2), EMIN);
      chk("R8", longint'(ovf[2]), 1);
      chk("R7", longint'(ovf[1]), 0);

      // R11: flags survive a clearing read
      cur_req = "R11";
      rd_clr_en = 1'b1;
      tick(1'b0, 3'b101);
      tick(1'b0, 3'b000);
      chk("R11", dut_nrg(0), 0); chk("R11", dut_nrg(2), 0);
      chk("R11", longint'(ovf), 5);
      for (int i = 0; i < 3; i++) tick(1'b1, 3'b000);
      tick(1'b0, 3'b000);
      chk("R11", longint'(ovf), 5);
      rd_clr_en = 1'b0;

      // mixed traffic, threshold fixed after reset, powers within +/- threshold
      cur_req = "R2";
      for (int seg = 0; seg < 4; seg++) begin
         int t;
         t = 1 + $urandom_range(0, 200000);
         do_reset(48'(t));
         for (int i = 0; i < 2500; i++) begin
            pwr_a = 32'($signed($urandom_range(0, 2*t)) - t);
            pwr_b = 32'($signed($urandom_range(0, 2*t)) - t);
            pwr_c = (i % 97 < 48) ? 32'(t) : 32'(-t);
            comb_mode = 2'($urandom_range(0, 3));
            rd_clr_en = ($urandom_range(0, 15) == 0);
            tick($urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)));
         end
         tick(1'b0, 3'b000);
      end

      tick(1'b0, 3'b000);
      finish_run();
   end

endmodule